// File: doc/BRIEF.md
# Strap-Selected Root Clock Enable Generator

This block derives two clock enables from a single fast crystal-domain clock. A three-bit mode strap is read while reset is held and frozen when reset is released. One strap bit decides whether the system enable fires on every fast cycle or on every second fast cycle. Another strap bit decides where the low-speed real-time enable comes from. It is either a slow external reference of about 32.768 kHz, which is synchronised and edge-detected, or a prescaler running on the fast clock. The prescaler divides by 1024, or by 2048 when the system enable is halved. The lowest strap bit only records whether the crystal is driven externally or oscillates. It has no effect on any ratio.

Both enables are single-cycle pulses in the fast clock domain, meant to qualify flops that run on the fast clock. A status word reports the frozen strap value together with a code for the real-time source that was selected.

Top module: `strap_clkgen`

## Requirements
- R1: While rst_n is low, the strap value is loaded on every clock edge. From the first edge with rst_n high it is held, whatever the strap pins do, and it appears on status[2:0] (strap bit 2 on status[2]).
- R2: With strap bit 1 at 0, sys_en is high on every fast cycle, starting with the first cycle after reset release.
- R3: With strap bit 1 at 1, sys_en alternates. It is low in the first cycle after release, high in the second, and continues high on even cycles only.
- R4: With strap bit 2 at 0, each rising edge of slow_in gives exactly one rtc_en pulse. If slow_in rises just before clock edge n, the pulse is visible after edge n+2.
- R5: With strap bits 2:1 = 10, rtc_en pulses once every 1024 fast cycles, first after the 1024th edge following release, and slow_in has no effect.
- R6: With strap bits 2:1 = 11, rtc_en pulses once every 2048 fast cycles (a halving stage followed by the 1024 prescaler), first after the 2048th edge, and slow_in has no effect.
- R7: Strap bit 0 changes no enable timing; modes that differ only in bit 0 produce identical enables.
- R8: Both enables are low while reset is held, and every pulse lasts exactly one fast cycle.
- R9: status[4:3] encodes the real-time source: 0 = slow input, 1 = prescale 1024, 2 = prescale 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast crystal-domain clock |
| rst_n | input | 1 | Active-low synchronous reset; straps load while low |
| strap | input | 3 | Mode strap pins, bit 2 down to bit 0 |
| slow_in | input | 1 | Asynchronous slow reference clock |
| sys_en | output | 1 | System clock enable pulse |
| rtc_en | output | 1 | Real-time clock enable pulse |
| status | output | 5 | {source code[1:0], frozen strap[2:0]} |

## Verification
The hardest case to reach is showing that the straps stay frozen. The frozen value has no visible effect unless the pins move after release. The stimulus therefore drives a different strap value in the middle of a prescaled run. It then requires both the status word and the pulse schedule, already queued for the original mode, to remain unchanged. A second hard case is showing that slow_in is ignored in the prescaled modes. To cover it, the slow input is toggled throughout those runs, and any extra pulse hits an empty or mismatched expectation queue.

// File: rtl/strap_clkgen.sv
module strap_clkgen #(
  parameter int PRESCALE = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap,
  input  logic       slow_in,
  output logic       sys_en,
  output logic       rtc_en,
  output logic [4:0] status
);
  localparam int CW = $clog2(PRESCALE);

  logic [2:0]    mode_q;
  logic          half_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    sync_q;
  logic          sys_q, rtc_q;

  wire tick      = ~mode_q[1] | half_q;
  wire wrap      = (cnt_q == CW'(PRESCALE - 1));
  wire slow_edge = sync_q[1] & ~sync_q[2];
  wire [1:0] src = mode_q[2] ? (mode_q[1] ? 2'd2 : 2'd1) : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= strap;
      half_q <= 1'b0;
      cnt_q  <= '0;
      sync_q <= '0;
      sys_q  <= 1'b0;
      rtc_q  <= 1'b0;
    end else begin
      half_q <= ~half_q;
      sys_q  <= tick;
      sync_q <= {sync_q[1:0], slow_in};
      if (mode_q[2] && tick)
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      rtc_q  <= mode_q[2] ? (tick & wrap) : slow_edge;
    end
  end

  assign sys_en = sys_q;
  assign rtc_en = rtc_q;
  assign status = {src, mode_q};

  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
  a_r2_sys_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !mode_q[1]) |-> sys_en);
  a_r3_sys_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && sys_en) |=> !sys_en);
  a_r8_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!sys_en && !rtc_en));
  a_r8_rtc_single: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_en |=> !rtc_en);
endmodule

// File: tb/strap_clkgen_test.sv
module strap_clkgen_test;
  localparam int PRE = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] strap = 3'd0;
  logic slow_in = 1'b0;
  logic sys_en, rtc_en;
  logic [4:0] status;

  int unsigned cyc = 0;
  int unsigned exp_q[$];
  int errors = 0;
  int checks = 0;
  logic [2:0] cur_mode = 3'd0;
  bit running = 1'b0;
  int sys_bad = 0;

  strap_clkgen #(.PRESCALE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .slow_in(slow_in),
    .sys_en(sys_en), .rtc_en(rtc_en), .status(status));

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected rtc pulse cycles, tracks sys_en pattern
  always @(negedge clk) begin
    if (running && rst_n && cyc >= 1) begin
      if (sys_en !== (cur_mode[1] ? (cyc % 2 == 0) : 1'b1)) sys_bad++;
      if (rtc_en) begin
        if (exp_q.size() == 0) check(0, "R4/R5/R6 unexpected rtc_en", int'(cyc), -1);
        else begin
          int unsigned e;
          e = exp_q.pop_front();
          check(cyc == e, "R4/R5/R6 rtc_en cycle", int'(cyc), int'(e));
        end
      end
    end
  end

  task automatic do_reset(input logic [2:0] m);
    running = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    strap = m;
    slow_in = 1'b0;
    repeat (4) @(negedge clk);
    check(sys_en == 1'b0 && rtc_en == 1'b0, "R8 quiet in reset", {sys_en, rtc_en}, 0);
    cur_mode = m;
    exp_q.delete();
    sys_bad = 0;
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check(status[2:0] == m, "R1 status straps", status[2:0], m);
    check(status[4:3] == (m[2] ? (m[1] ? 2 : 1) : 0), "R9 source code",
          status[4:3], m[2] ? (m[1] ? 2 : 1) : 0);
  endtask

  task automatic run_mode(input logic [2:0] m, input bit swap_strap);
    int mul;
    do_reset(m);
    if (!m[2]) begin
      for (int k = 0; k < 4; k++) begin
        repeat (7 + k) @(negedge clk);
        slow_in = 1'b1;
        exp_q.push_back(cyc + 3);
        repeat (5) @(negedge clk);
        slow_in = 1'b0;
      end
      repeat (8) @(negedge clk);
    end else begin
      mul = m[1] ? 2 : 1;
      for (int j = 1; j <= 3; j++) exp_q.push_back(PRE * mul * j);
      while (cyc < 3 * PRE * mul + 6) begin
        @(negedge clk);
        if (cyc % 37 == 0) slow_in = ~slow_in;
        if (swap_strap && cyc == 100) strap = ~m;
      end
      if (swap_strap)
        check(status[2:0] == m, "R1 straps frozen after release", status[2:0], m);
    end
    check(exp_q.size() == 0, m[2] ? (m[1] ? "R6 pulses missing" : "R5 pulses missing")
          : "R4 pulses missing", exp_q.size(), 0);
    check(sys_bad == 0, m[1] ? "R3 sys_en alternation" : "R2 sys_en every cycle", sys_bad, 0);
    if (m[0]) check(sys_bad == 0 && exp_q.size() == 0, "R7 bit0 no effect", sys_bad, 0);
  endtask

  initial begin
    fork
      begin
        for (int m = 0; m < 8; m++) run_mode(3'(m), m == 6);
        run_mode(3'd5, 1'b1);
      end
      begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule